// File: doc/BRIEF.md
# Framebuffer pixel format unpacker

This block sits between a display fetch engine and a panel pipeline. It accepts 32-bit framebuffer words on a valid/ready stream and sends out 24-bit RGB pixels on a second valid/ready stream. A 4-bit format code sets how the bytes of each word are read. The supported layouts are two 16-bit layouts (5-6-5, and 1-5-5-5 with a transparency bit), packed 24-bit colour that crosses word boundaries, 32-bit colour with an unused top byte, 32-bit colour with alpha, and 8-bit indices into a 256-entry colour palette.

Incoming words go into a small byte buffer. Each format takes its own number of bytes per pixel from the bottom of that buffer. Bytes stored first come out first, so within each word the lowest byte is taken first. A pixel whose channels are narrower than 8 bits is widened by copying the top bits of each channel into the freed low bits. The last stage can exchange red and blue. Software loads the palette in two steps: a colour write, followed by a command word that carries the entry index.

The format code, the swap bits and the palette contents must stay constant while a stream is being converted.

Top module: `fb_pixel_unpack`

## Requirements
- R1: While reset is applied and right after it is released, out_valid is 0 and in_ready is 1.
- R2: Format code 0 (5-6-5) decodes red from bits 15:11, green from 10:5 and blue from 4:0. Each channel is widened by copying its top bits. The lower halfword of a word is emitted before the upper halfword.
- R3: Format code 1 (1-5-5-5) decodes red from bits 14:10, green from 9:5 and blue from 4:0, with the same widening. Bit 15 has no effect on the pixel. The lower halfword is emitted first.
- R4: Format code 2 (packed 24-bit) takes three bytes per pixel in byte order across word boundaries, with the lowest byte as blue and the third byte as red. Three words give four pixels.
- R5: Format code 3 emits bits 23:0 of each word as red (23:16), green (15:8) and blue (7:0), one pixel per word. Format code 4 does the same and discards the alpha byte 31:24. Codes 6 to 15 behave like code 3.
- R6: Format code 5 (palette) emits four pixels per word, lowest byte first. Each byte selects one of 256 palette entries. Each entry holds red in bits 23:16, green in 15:8 and blue in 7:0.
- R7: A pulse on pal_data_we stores pal_wr_data in a colour register. A pulse on pal_ctrl_we with pal_ctrl[15:8] = 0x83 writes that colour register into the palette entry pal_ctrl[7:0]. A command with any other upper byte leaves the palette unchanged.
- R8: When fmt_swap XOR panel_swap is 1, the red and blue bytes of every output pixel are exchanged. This applies to all formats.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_pixel keeps its value.
- R10: in_ready is 1 whenever no complete pixel is buffered. In format code 3, a new word is accepted on every cycle in which a pixel is taken. While a 16-bit pixel is stalled with a full word held, in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_code | input | 4 | Source layout select |
| fmt_swap | input | 1 | Red/blue swap bit of the selected format |
| panel_swap | input | 1 | Red/blue swap bit of the panel |
| pal_wr_data | input | 24 | Colour to be loaded into the palette |
| pal_data_we | input | 1 | Loads pal_wr_data into the colour register |
| pal_ctrl | input | 16 | Palette command: 0x83 in the upper byte, entry index in the lower byte |
| pal_ctrl_we | input | 1 | Issues the palette command |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts a word |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 24 | Pixel, red in 23:16, green in 15:8, blue in 7:0 |

## Verification
The assertions check the stream handshake on every cycle:
- a stalled pixel holds its value;
- an empty buffer always accepts a word;
- a word accepted into an empty buffer in a 16-bit or 32-bit layout yields a pixel on the next cycle, and in the 32-bit layout that pixel carries the word's colour bits.

Only the bench scenarios can show the rest:
- the channel widening;
- the ordering of pixels within a word and across words in packed 24-bit mode;
- the palette command decode and the lookup contents;
- the XOR of the two swap bits.

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  fmt_code,
  input  logic        fmt_swap,
  input  logic        panel_swap,
  input  logic [23:0] pal_wr_data,
  input  logic        pal_data_we,
  input  logic [15:0] pal_ctrl,
  input  logic        pal_ctrl_we,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_pixel
);
  localparam logic [3:0] FMT_565    = 4'd0;
  localparam logic [3:0] FMT_1555   = 4'd1;
  localparam logic [3:0] FMT_PACKED = 4'd2;
  localparam logic [3:0] FMT_PAL    = 4'd5;
  localparam logic [7:0] PAL_CMD    = 8'h83;
  localparam int         BUF_BYTES  = 7;
  localparam int         BUF_W      = BUF_BYTES * 8;

  logic [BUF_W-1:0] bytes_q;
  logic [2:0]       cnt_q;
  logic [2:0]       bpp;
  logic [2:0]       cnt_left;
  logic             take_pix;
  logic             take_word;
  logic [23:0]      lo;
  logic [23:0]      rgb;
  logic [23:0]      pal_data_q;
  logic [23:0]      pal_mem [256];

  always_comb begin
    case (fmt_code)
      FMT_565, FMT_1555: bpp = 3'd2;
      FMT_PACKED:        bpp = 3'd3;
      FMT_PAL:           bpp = 3'd1;
      default:           bpp = 3'd4;
    endcase
  end

  assign out_valid = cnt_q >= bpp;
  assign take_pix  = out_valid & out_ready;
  assign cnt_left  = take_pix ? cnt_q - bpp : cnt_q;
  assign in_ready  = cnt_left <= 3'd3;
  assign take_word = in_valid & in_ready;
  assign lo        = bytes_q[23:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      cnt_q   <= '0;
    end else begin
      bytes_q <= (bytes_q >> {take_pix ? bpp : 3'd0, 3'b000})
               | (take_word ? ({24'h0, in_word} << {cnt_left, 3'b000}) : '0);
      cnt_q   <= cnt_left + (take_word ? 3'd4 : 3'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pal_data_q <= '0;
    else if (pal_data_we) pal_data_q <= pal_wr_data;
  end

  always_ff @(posedge clk) begin
    if (pal_ctrl_we && pal_ctrl[15:8] == PAL_CMD)
      pal_mem[pal_ctrl[7:0]] <= pal_data_q;
  end

  always_comb begin
    case (fmt_code)
      FMT_565:  rgb = {lo[15:11], lo[15:13], lo[10:5], lo[10:9], lo[4:0], lo[4:2]};
      FMT_1555: rgb = {lo[14:10], lo[14:12], lo[9:5], lo[9:7], lo[4:0], lo[4:2]};
      FMT_PAL:  rgb = pal_mem[lo[7:0]];
      default:  rgb = lo;
    endcase
  end

  assign out_pixel = (fmt_swap ^ panel_swap) ? {rgb[7:0], rgb[15:8], rgb[23:16]} : rgb;
endmodule

// File: rtl/fb_pixel_unpack_chk.sv
module fb_pixel_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  fmt_code,
  input logic        fmt_swap,
  input logic        panel_swap,
  input logic        pal_ctrl_we,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_pixel
);
  logic [5:0] cfg;
  assign cfg = {fmt_code, fmt_swap, panel_swap};

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !pal_ctrl_we |=>
      !$stable(cfg) || (out_valid && $stable(out_pixel)));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_unpacked_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !out_valid && fmt_code == 4'd3 && !(fmt_swap ^ panel_swap) |=>
      !$stable(cfg) || (out_valid && out_pixel == $past(in_word[23:0])));

  p_halfword_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !out_valid && fmt_code == 4'd0 |=>
      !$stable(cfg) || out_valid);
endmodule

bind fb_pixel_unpack fb_pixel_unpack_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .fmt_swap(fmt_swap),
  .panel_swap(panel_swap), .pal_ctrl_we(pal_ctrl_we), .in_valid(in_valid),
  .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
  .out_ready(out_ready), .out_pixel(out_pixel)
);

// File: tb/test_fb_pixel_unpack.sv
`timescale 1ns/1ps
module test_fb_pixel_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt_code = '0;
  logic        fmt_swap = 1'b0, panel_swap = 1'b0;
  logic [23:0] pal_wr_data = '0;
  logic        pal_data_we = 1'b0;
  logic [15:0] pal_ctrl = '0;
  logic        pal_ctrl_we = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_pixel;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fb_pixel_unpack i_fb_pixel_unpack (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .fmt_swap(fmt_swap),
    .panel_swap(panel_swap), .pal_wr_data(pal_wr_data), .pal_data_we(pal_data_we),
    .pal_ctrl(pal_ctrl), .pal_ctrl_we(pal_ctrl_we), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_pixel(out_pixel)
  );

  // {req, fmt, fmt_swap, panel_swap, word, count, p0, p1, p2, p3}
  localparam int NV = 13;
  localparam logic [140:0] VECS [NV] = '{
    {4'd2,  4'd0, 1'b0, 1'b0, 32'hF80007E0, 3'd2, 24'h00FF00, 24'hFF0000, 24'h0, 24'h0},   // R2
    {4'd2,  4'd0, 1'b0, 1'b0, 32'h001F8410, 3'd2, 24'h848284, 24'h0000FF, 24'h0, 24'h0},   // R2
    {4'd8,  4'd0, 1'b1, 1'b0, 32'h0000F800, 3'd2, 24'h0000FF, 24'h000000, 24'h0, 24'h0},   // R8
    {4'd8,  4'd0, 1'b1, 1'b1, 32'h0000F800, 3'd2, 24'hFF0000, 24'h000000, 24'h0, 24'h0},   // R8
    {4'd3,  4'd1, 1'b0, 1'b0, 32'hFC007FFF, 3'd2, 24'hFFFFFF, 24'hFF0000, 24'h0, 24'h0},   // R3
    {4'd3,  4'd1, 1'b0, 1'b0, 32'h800003E0, 3'd2, 24'h00FF00, 24'h000000, 24'h0, 24'h0},   // R3
    {4'd5,  4'd3, 1'b0, 1'b0, 32'hAB123456, 3'd1, 24'h123456, 24'h0, 24'h0, 24'h0},        // R5
    {4'd8,  4'd3, 1'b0, 1'b1, 32'h00112233, 3'd1, 24'h332211, 24'h0, 24'h0, 24'h0},        // R8
    {4'd5,  4'd4, 1'b0, 1'b0, 32'h7FA0B0C0, 3'd1, 24'hA0B0C0, 24'h0, 24'h0, 24'h0},        // R5
    {4'd5,  4'd9, 1'b0, 1'b0, 32'hFF654321, 3'd1, 24'h654321, 24'h0, 24'h0, 24'h0},        // R5
    {4'd6,  4'd5, 1'b0, 1'b0, 32'h03020100, 3'd4, 24'h102030, 24'hA1B2C3, 24'h0000FF, 24'hFFFFFF}, // R6
    {4'd6,  4'd5, 1'b0, 1'b0, 32'h00FF0201, 3'd4, 24'hA1B2C3, 24'h0000FF, 24'h7E8F90, 24'h102030}, // R6
    {4'd8,  4'd5, 1'b0, 1'b1, 32'h00000002, 3'd4, 24'hFF0000, 24'h302010, 24'h302010, 24'h302010}  // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic take(input logic [23:0] exp, input string tag);
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    chk(tag, {8'h0, out_pixel}, {8'h0, exp});
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic pal_load(input logic [23:0] data);
    @(negedge clk);
    pal_wr_data = data;
    pal_data_we = 1'b1;
    @(negedge clk);
    pal_data_we = 1'b0;
  endtask

  task automatic pal_cmd(input logic [15:0] cmd);
    @(negedge clk);
    pal_ctrl    = cmd;
    pal_ctrl_we = 1'b1;
    @(negedge clk);
    pal_ctrl_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [3:0] f, input logic fs, input logic ps);
    @(negedge clk);
    fmt_code   = f;
    fmt_swap   = fs;
    panel_swap = ps;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'h0, out_valid}, 32'h0);
    chk("R1 in_ready in reset", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'h0, out_valid}, 32'h0);
    chk("R1 in_ready after reset", {31'h0, in_ready}, 32'h1);

    // R7: palette loading through colour register then command
    pal_load(24'h102030); pal_cmd(16'h8300);
    pal_load(24'hA1B2C3); pal_cmd(16'h8301);
    pal_load(24'h0000FF); pal_cmd(16'h8302);
    pal_load(24'hFFFFFF); pal_cmd(16'h8303);
    pal_load(24'h7E8F90); pal_cmd(16'h83FF);

    for (int i = 0; i < NV; i++) begin
      logic [140:0] v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vector %0d", v[140:137], i);
      set_cfg(v[136:133], v[132], v[131]);
      send(v[130:99]);
      for (int k = 0; k < int'(v[98:96]); k++)
        take(v[95 - 24*k -: 24], tag);
    end

    // R4: packed 24-bit across word boundaries
    set_cfg(4'd2, 1'b0, 1'b0);
    send(32'h03020100); take(24'h020100, "R4 pixel0");
    send(32'h07060504); take(24'h050403, "R4 pixel1");
    send(32'h0B0A0908); take(24'h080706, "R4 pixel2");
    take(24'h0B0A09, "R4 pixel3");

    // R7: a command with the wrong upper byte leaves entry 3 unchanged
    pal_load(24'hDEAD01);
    pal_cmd(16'h8203);
    set_cfg(4'd5, 1'b0, 1'b0);
    send(32'h00000003);
    take(24'hFFFFFF, "R7 ignored command");
    for (int k = 0; k < 3; k++) take(24'h102030, "R7 ignored command tail");
    pal_cmd(16'h8303);
    send(32'h00000003);
    take(24'hDEAD01, "R7 valid command");
    for (int k = 0; k < 3; k++) take(24'h102030, "R7 valid command tail");

    // R9 and R10: a stalled pixel holds and no word is accepted
    set_cfg(4'd0, 1'b0, 1'b0);
    send(32'hF80007E0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held valid", {31'h0, out_valid}, 32'h1);
      chk("R9 held pixel", {8'h0, out_pixel}, 32'h00FF00);
      chk("R10 ready low while full", {31'h0, in_ready}, 32'h0);
    end
    take(24'h00FF00, "R9 drain0");
    take(24'hFF0000, "R9 drain1");

    // R10: one word per cycle in 32-bit mode
    set_cfg(4'd3, 1'b0, 1'b0);
    out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k > 0) chk("R10 burst pixel", {8'h0, out_pixel}, 32'h00102030 + (k-1) * 32'h00010101);
      chk("R10 burst ready", {31'h0, in_ready}, 32'h1);
      in_word  = 32'hEE102030 + k * 32'h00010101;
      in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 burst last", {8'h0, out_pixel}, 32'h00102030 + 4 * 32'h00010101);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R10 burst drained", {31'h0, out_valid}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule